// File: doc/BRIEF.md
# Fractional Predivider Clock Divider

This block turns a reference clock into a slower divided clock and a matching one-cycle clock-enable. The division ratio is the product of a half-step predivider (2, 2.5 or 3) and a 7-bit integer divider. To keep all logic synchronous, the block runs from a reference at twice the rate of the chosen source, so the half-step predivider becomes a whole number of reference cycles. One output period lasts N = (P + 3) × D reference cycles, where P is the 2-bit predivider code and D is the integer divider. The output frequency is therefore 2 × source / N.

A single 32-bit control word configures the block. It holds an enable bit, a 2-bit source-select field that picks the crystal, PLL1 or PLL2, and the P and D fields. The decoded source selection is driven out as `src_sel` so that the surrounding logic can steer the doubled reference. A new divider setting takes effect only at the end of the current output period. A change of source silences the output until that boundary, and counting then restarts on the new source.

Top module: `frac_clkdiv`

## Requirements
- R1: After reset, the control word reads 0x00000000 and `clk_out`, `clk_en` and `src_sel` are all zero.
- R2: A write stores every bit of `wr_data` into the control word except bit 7. Bit 7 is reserved and always reads 0.
- R3: The control word holds the enable in bit 15, P in bits 9:8 and D in bits 6:0. When the enable is set and both P and D are nonzero, `clk_en` pulses for one cycle every N = (P + 3) × D reference cycles.
- R4: Each output period starts on the `clk_en` cycle. `clk_out` is high for the first floor(N/2) cycles of the period and low for the rest.
- R5: P = 0 or D = 0 stops the divider. `clk_out` and `clk_en` then stay low.
- R6: When bit 15 is clear, `clk_out` is low and `clk_en` is inactive from the first cycle after the write.
- R7: The source-select field is bits 14:13. Bit 14 alone gives `src_sel` = 1 (PLL1). Both bits set give `src_sel` = 2 (PLL2). Any other pattern gives `src_sel` = 0 (crystal).
- R8: A new P or D written while the divider runs takes effect only at the next period boundary, so the period in progress keeps its old length.
- R9: After a source-select change, `clk_out` and `clk_en` stay low until the current period boundary. `src_sel` changes only while `clk_out` is low, and a full period of the configured length then starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Doubled-rate reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| src_sel | output | 2 | Active source: 0 crystal, 1 PLL1, 2 PLL2 |
| clk_en | output | 1 | One-cycle pulse at the start of each output period |
| clk_out | output | 1 | Divided clock |

## Verification
The bench covers the extremes of the ratio range: the shortest period (N = 4), the longest (N = 762) and an odd N whose high phase rounds down. A design that rounds the duty cycle up, or that miscounts the +3 offset, would give the wrong period or the wrong high count. It also writes a new divider one cycle into a period. A design that reloads at once would produce a truncated period instead of finishing the old one. Source switching is checked for any high cycle between the write and the handover, and for a short first period on the new source. The bench also checks the reserved bit, each of the four select patterns, and the stopped behaviour under zero P, zero D and a cleared enable.

// File: rtl/frac_clkdiv.sv
module frac_clkdiv #(
  parameter int REG_W  = 32,
  parameter int DIV_W  = 7,
  parameter int PDIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic [1:0]       src_sel,
  output logic             clk_en,
  output logic             clk_out
);
  localparam int PDIV_LSB = 8;
  localparam int RSV_BIT  = 7;
  localparam int SEL_LSB  = 13;
  localparam int EN_BIT   = 15;
  localparam int N_W      = DIV_W + $clog2(2**PDIV_W + 2);

  logic [REG_W-1:0] ctrl_q;
  logic [N_W-1:0]   cnt, act_n;
  logic             act_run;
  logic [1:0]       act_src, dec_src;

  wire [PDIV_W-1:0] pdiv    = ctrl_q[PDIV_LSB +: PDIV_W];
  wire [DIV_W-1:0]  div     = ctrl_q[DIV_W-1:0];
  wire              en      = ctrl_q[EN_BIT];
  wire [N_W-1:0]    new_n   = (N_W'(pdiv) + N_W'(3)) * N_W'(div);
  wire              new_run = en && (pdiv != '0) && (div != '0);
  wire              mute    = act_run && (dec_src != act_src);
  wire              load    = !act_run || !en || (cnt == act_n - N_W'(1));
  wire              live    = act_run && en && !mute;

  always_comb begin
    case (ctrl_q[SEL_LSB +: 2])
      2'b10:   dec_src = 2'd1;
      2'b11:   dec_src = 2'd2;
      default: dec_src = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt     <= '0;
      act_n   <= '0;
      act_run <= 1'b0;
      act_src <= 2'd0;
    end else begin
      if (wr_en)
        ctrl_q <= {wr_data[REG_W-1:RSV_BIT+1], ctrl_q[RSV_BIT], wr_data[RSV_BIT-1:0]};
      if (load) begin
        cnt     <= '0;
        act_n   <= new_n;
        act_run <= new_run;
        act_src <= dec_src;
      end else begin
        cnt <= cnt + N_W'(1);
      end
    end
  end

  assign ctrl_rdata = ctrl_q;
  assign src_sel    = act_src;
  assign clk_en     = live && (cnt == '0);
  assign clk_out    = live && (cnt < (act_n >> 1));

  // R2
  wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_rdata[PDIV_LSB +: PDIV_W] == $past(wr_data[PDIV_LSB +: PDIV_W]))
              && (ctrl_rdata[RSV_BIT] == $past(ctrl_rdata[RSV_BIT])));

  // R3
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> !clk_en);

  // R4
  en_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> clk_out);

  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[EN_BIT] |=> !clk_out || ctrl_rdata[EN_BIT]);

  // R9
  src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |-> !$past(clk_out));
endmodule

// File: tb/tb_frac_clkdiv.sv
module tb_frac_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_rdata;
  logic [1:0]  src_sel;
  logic        clk_en, clk_out;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_clkdiv dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rdata(ctrl_rdata), .src_sel(src_sel), .clk_en(clk_en), .clk_out(clk_out)
  );

  function automatic logic [31:0] cfg(bit e, logic [1:0] sel, logic [1:0] p, logic [6:0] d);
    return {16'h0, e, sel, 3'b000, p, 1'b0, d};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_en(output bit ok);
    int n = 0;
    while (!clk_en && n < TMO) begin @(negedge clk); n++; end
    ok = clk_en;
  endtask

  task automatic meas(output int per, output int hi);
    bit ok;
    wait_en(ok);
    per = 0; hi = 0;
    do begin
      hi += int'(clk_out); per++;
      @(negedge clk);
    end while (!clk_en && per < TMO);
  endtask

  task automatic t_reset();
    check(ctrl_rdata == 32'h0, "R1 ctrl", int'(ctrl_rdata), 0);
    check(!clk_out && !clk_en, "R1 outputs", int'(clk_out) + int'(clk_en), 0);
    check(src_sel == 2'd0, "R1 src_sel", int'(src_sel), 0);
  endtask

  task automatic t_period(logic [1:0] p, logic [6:0] d);
    int per, hi;
    int n = (int'(p) + 3) * int'(d);
    wr(cfg(1'b1, 2'b00, p, d));
    meas(per, hi);
    meas(per, hi);
    check(per == n, "R3 period", per, n);
    check(hi == n / 2, "R4 high cycles", hi, n / 2);
  endtask

  task automatic t_zero(logic [1:0] p, logic [6:0] d);
    int act = 0;
    wr(cfg(1'b1, 2'b00, p, d));
    repeat (800) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      act += int'(clk_out) + int'(clk_en);
      @(negedge clk);
    end
    check(act == 0, "R5 zero setting silent", act, 0);
  endtask

  task automatic t_disable();
    int per, hi;
    int act = 0;
    wr(cfg(1'b1, 2'b00, 2'd1, 7'd8));
    meas(per, hi);
    repeat (2) @(negedge clk);
    wr(cfg(1'b0, 2'b00, 2'd1, 7'd8));
    for (int i = 0; i < 60; i++) begin
      act += int'(clk_out) + int'(clk_en);
      @(negedge clk);
    end
    check(act == 0, "R6 enable clear", act, 0);
  endtask

  task automatic t_rsv();
    wr(32'h1234_0080);
    check(ctrl_rdata == 32'h1234_0000, "R2 readback", int'(ctrl_rdata), 32'h1234_0000);
    wr(32'hFFFF_7FFF);
    check(ctrl_rdata == 32'hFFFF_7F7F, "R2 bit7 reserved", int'(ctrl_rdata), 32'hFFFF_7F7F);
    wr(32'h0);
  endtask

  task automatic t_src();
    logic [1:0] pat [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    int exp [4] = '{0, 0, 1, 2};
    for (int i = 0; i < 4; i++) begin
      wr(cfg(1'b1, pat[i], 2'd1, 7'd2));
      repeat (20) @(negedge clk);
      check(src_sel == 2'(exp[i]), "R7 source decode", int'(src_sel), exp[i]);
    end
    wr(cfg(1'b1, 2'b00, 2'd1, 7'd2));
    repeat (20) @(negedge clk);
  endtask

  task automatic t_update();
    bit ok;
    int per = 0, hi;
    wr(cfg(1'b1, 2'b00, 2'd1, 7'd2));
    wait_en(ok); @(negedge clk);
    wait_en(ok);
    wr_en = 1'b1; wr_data = cfg(1'b1, 2'b00, 2'd3, 7'd2);
    do begin
      per++;
      @(negedge clk); wr_en = 1'b0;
    end while (!clk_en && per < TMO);
    check(per == 8, "R8 old period finished", per, 8);
    meas(per, hi);
    check(per == 12, "R8 new period applied", per, 12);
  endtask

  task automatic t_switch();
    bit ok;
    int per, hi;
    int act = 0, n = 0;
    wr(cfg(1'b1, 2'b00, 2'd1, 7'd4));
    wait_en(ok); @(negedge clk);
    wait_en(ok);
    repeat (3) @(negedge clk);
    wr(cfg(1'b1, 2'b11, 2'd1, 7'd4));
    while (src_sel != 2'd2 && n < TMO) begin
      act += int'(clk_out) + int'(clk_en);
      n++;
      @(negedge clk);
    end
    check(act == 0, "R9 muted before switch", act, 0);
    check(n <= 16, "R9 switch at boundary", n, 16);
    meas(per, hi);
    check(per == 16 && hi == 8, "R9 full period after switch", per, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_period(2'd1, 7'd2);
    t_period(2'd1, 7'd1);
    t_period(2'd2, 7'd3);
    t_period(2'd2, 7'd1);
    t_period(2'd3, 7'd127);
    t_zero(2'd0, 7'd5);
    t_period(2'd1, 7'd2);
    t_zero(2'd2, 7'd0);
    t_disable();
    t_rsv();
    t_src();
    t_update();
    t_switch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule